// File: doc/BRIEF.md
# Serial Control Word Receiver with Per-Channel Attenuation Registers

This block receives configuration over a three-wire, write-only serial link and keeps the resulting settings in registers. The three lines are a shift clock, a data line and a load strobe. A host shifts 16-bit words in, most significant bit first, one bit on each rising edge of the shift clock. It then pulses the load strobe, and the word is committed into the register that the word itself addresses. The shift clock may stop at any time between bits. None of the logic relies on it running freely.

All logic runs on a single system clock. The three serial lines are asynchronous to it, so each passes through a two-flop synchroniser. After that, rising edges of the shift clock and of the load strobe are detected. Each word selects one of three targets: a left-channel register, a right-channel register or a mode register. The two channel registers hold a 10-bit attenuation value and a mute bit. The mode register holds a 2-bit de-emphasis curve selection. All settings reach the outputs through registers.

Top module: `ctrl_port_regs`

## Requirements
- R1: While `rst` is high at a clock edge, both attenuation outputs become 10'h3FF, both mute outputs become 0 and `deemph_sel` becomes 2'b00 (the 44.1 kHz curve).
- R2: A committed word with bits [15:14] = 2'b00 loads `left_atten` from bits [9:0] and `left_mute` from bit 13. Bits [12:10] have no effect, and the right-channel and mode outputs keep their values.
- R3: A committed word with bits [15:14] = 2'b01 loads `right_atten` from bits [9:0] and `right_mute` from bit 13. The left-channel and mode outputs keep their values.
- R4: A committed word with bits [15:14] = 2'b10 loads `deemph_sel` from bits [1:0], coded 00 = 44.1 kHz, 01 = 32 kHz and 10 = 48 kHz. Both channel outputs keep their values.
- R5: A committed word with bits [15:14] = 2'b11 changes no output.
- R6: A rising edge of `ser_ld` seen when fewer than 16 bits have arrived since the previous load edge or reset changes no output. It discards the bits received so far.
- R7: When more than 16 bits arrive before a load edge, only the last 16 bits, taken MSB first, form the committed word.
- R8: Outputs change only in the system clock cycle after a detected rising edge of `ser_ld`. Bits that have been shifted in without a load edge change nothing, and a later load edge still commits them.
- R9: Gaps of any length between shift clock pulses, with `ser_clk` held low, do not change the word that is received.
- R10: Reset also clears any partly received word, so bits shifted in before reset do not count toward the 16 that a commit needs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, asynchronous, may be gated |
| ser_dat | input | 1 | Serial data, MSB first, sampled on rising edge of ser_clk |
| ser_ld | input | 1 | Load strobe, commits the word on its rising edge |
| left_atten | output | 10 | Left channel attenuation setting |
| left_mute | output | 1 | Left channel mute setting |
| right_atten | output | 10 | Right channel attenuation setting |
| right_mute | output | 1 | Right channel mute setting |
| deemph_sel | output | 2 | De-emphasis curve select |

## Verification
The bench sends words to each of the four target codes, using alternating and opposite bit patterns in the attenuation field and setting the ignored bits [12:10]. A bit-order or field-offset error therefore shows up as a wrong value and cannot be mistaken for a correct one. Load pulses after 12, 16 and 24 bits separate the discard, exact-length and keep-last-16 cases. Bits shifted with no load pulse, followed by a load pulse alone, show that the commit happens on the strobe and not on the sixteenth bit. Long random pauses in the shift clock and a reset in the middle of a word check that pauses change nothing and that reset clears the bit counter.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int WORD_W = 16;
  localparam int ATT_W  = 10;
  localparam int DE_W   = 2;
  localparam int TGT_W  = 2;
  localparam int TGT_HI = WORD_W - 1;
  localparam int MUTE_B = WORD_W - TGT_W - 1;

  typedef enum logic [TGT_W-1:0] {
    TGT_LEFT  = 2'b00,
    TGT_RIGHT = 2'b01,
    TGT_MODE  = 2'b10,
    TGT_RSVD  = 2'b11
  } tgt_e;

  typedef struct packed {
    logic [ATT_W-1:0] att;
    logic             mute;
  } chan_cfg_t;

  localparam chan_cfg_t CHAN_DEFAULT = '{att: '1, mute: 1'b0};
  localparam logic [DE_W-1:0] DE_DEFAULT = '0;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ctl_edge.sv
module ctl_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~prev[i];
  end
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              ld_stb,
  output logic [WORD_W-1:0] word,
  output logic              commit
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;

  assign full   = (cnt_q == FULL);
  assign commit = ld_stb & full;
  assign word   = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (ld_stb) begin
      cnt_q <= '0;
    end else if (bit_stb) begin
      sh_q <= {sh_q[WORD_W-2:0], bit_val};
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctrl_port_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output chan_cfg_t [NCH-1:0] ch_cfg,
  output logic [DE_W-1:0]   de_sel
);
  logic [TGT_W-1:0] tgt;
  assign tgt = word[TGT_HI -: TGT_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_cfg[c] <= CHAN_DEFAULT;
      end else if (commit && tgt == TGT_W'(c)) begin
        ch_cfg[c].att  <= word[ATT_W-1:0];
        ch_cfg[c].mute <= word[MUTE_B];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_sel <= DE_DEFAULT;
    end else if (commit && tgt == TGT_MODE) begin
      de_sel <= word[DE_W-1:0];
    end
  end
endmodule

// File: rtl/ctrl_port_regs.sv
module ctrl_port_regs
  import ctrl_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_ld,
  output logic [ATT_W-1:0] left_atten,
  output logic             left_mute,
  output logic [ATT_W-1:0] right_atten,
  output logic             right_mute,
  output logic [DE_W-1:0]  deemph_sel
);
  localparam int NCH = 2;

  logic [2:0]         s_lines;
  logic [1:0]         edges;
  logic               bit_rise;
  logic               ld_rise;
  logic               commit;
  logic [WORD_W-1:0]  shift_word;
  chan_cfg_t [NCH-1:0] cfg;

  ctl_sync #(.N(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_ld, ser_dat, ser_clk}),
    .dout(s_lines)
  );

  ctl_edge #(.N(2)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl ({s_lines[2], s_lines[0]}),
    .rise(edges)
  );

  assign bit_rise = edges[0];
  assign ld_rise  = edges[1];

  ctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .bit_stb(bit_rise),
    .bit_val(s_lines[1]),
    .ld_stb (ld_rise),
    .word   (shift_word),
    .commit (commit)
  );

  ctl_bank #(.NCH(NCH)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .commit(commit),
    .word  (shift_word),
    .ch_cfg(cfg),
    .de_sel(deemph_sel)
  );

  assign left_atten  = cfg[0].att;
  assign left_mute   = cfg[0].mute;
  assign right_atten = cfg[1].att;
  assign right_mute  = cfg[1].mute;
endmodule

// File: rtl/ctrl_port_chk.sv
module ctrl_port_chk
  import ctrl_port_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ATT_W-1:0]  left_atten,
  input logic              left_mute,
  input logic [ATT_W-1:0]  right_atten,
  input logic              right_mute,
  input logic [DE_W-1:0]   deemph_sel,
  input logic              commit,
  input logic              ld_rise,
  input logic [WORD_W-1:0] word
);
  logic [TGT_W-1:0] tgt;
  assign tgt = word[TGT_HI -: TGT_W];

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (left_atten == '1 && right_atten == '1 &&
                    !left_mute && !right_mute && deemph_sel == '0));

  // R2
  left_load_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && tgt == TGT_LEFT) |=>
      (left_atten == $past(word[ATT_W-1:0]) && left_mute == $past(word[MUTE_B]) &&
       $stable(right_atten) && $stable(right_mute) && $stable(deemph_sel)));

  // R3
  right_load_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && tgt == TGT_RIGHT) |=>
      (right_atten == $past(word[ATT_W-1:0]) && right_mute == $past(word[MUTE_B]) &&
       $stable(left_atten) && $stable(left_mute) && $stable(deemph_sel)));

  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && tgt == TGT_MODE) |=>
      (deemph_sel == $past(word[DE_W-1:0]) &&
       $stable(left_atten) && $stable(right_atten)));

  // R5
  reserved_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && tgt == TGT_RSVD) |=>
      ($stable(left_atten) && $stable(left_mute) && $stable(right_atten) &&
       $stable(right_mute) && $stable(deemph_sel)));

  // R6
  short_word_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_rise && !commit) |=>
      ($stable(left_atten) && $stable(left_mute) && $stable(right_atten) &&
       $stable(right_mute) && $stable(deemph_sel)));

  // R8
  no_commit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_rise)) |->
      ($stable(left_atten) && $stable(left_mute) && $stable(right_atten) &&
       $stable(right_mute) && $stable(deemph_sel)));

  // R8
  commit_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> ld_rise);
endmodule

bind ctrl_port_regs ctrl_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .left_atten (left_atten),
  .left_mute  (left_mute),
  .right_atten(right_atten),
  .right_mute (right_mute),
  .deemph_sel (deemph_sel),
  .commit     (commit),
  .ld_rise    (ld_rise),
  .word       (shift_word)
);

// File: tb/ctrl_port_regs_test.sv
module ctrl_port_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_ld = 1'b0;
  logic [9:0] left_atten, right_atten;
  logic left_mute, right_mute;
  logic [1:0] deemph_sel;

  always #2 clk = ~clk;

  ctrl_port_regs uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .left_atten(left_atten), .left_mute(left_mute),
    .right_atten(right_atten), .right_mute(right_mute),
    .deemph_sel(deemph_sel)
  );

  typedef struct packed {
    logic [9:0] la;
    logic       lm;
    logic [9:0] ra;
    logic       rm;
    logic [1:0] de;
  } exp_t;

  exp_t  exq[$];
  string tagq[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  exp_t        m;
  logic [15:0] m_sh;
  int          m_cnt;

  function automatic exp_t dflt();
    exp_t e;
    e.la = 10'h3FF; e.lm = 1'b0; e.ra = 10'h3FF; e.rm = 1'b0; e.de = 2'b00;
    return e;
  endfunction

  function automatic void model_commit(input logic [15:0] w);
    case (w[15:14])
      2'b00: begin m.la = w[9:0]; m.lm = w[13]; end
      2'b01: begin m.ra = w[9:0]; m.rm = w[13]; end
      2'b10: m.de = w[1:0];
      default: ;
    endcase
  endfunction

  task automatic push(input string tag);
    exq.push_back(m);
    tagq.push_back(tag);
    repeat (24) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n, input int gapmax);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_dat = bits[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat ($urandom_range(gapmax, 0)) @(negedge clk);
      m_sh = {m_sh[14:0], bits[i]};
      if (m_cnt < 16) m_cnt++;
    end
  endtask

  task automatic load();
    repeat (3) @(negedge clk);
    ser_ld = 1'b1;
    repeat (4) @(negedge clk);
    ser_ld = 1'b0;
    if (m_cnt >= 16) model_commit(m_sh);
    m_cnt = 0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m = dflt();
    m_cnt = 0;
    push(tag);
  endtask

  task automatic cmp(input string tag, input string fld, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      wait (exq.size() > 0);
      repeat (12) @(negedge clk);
      begin
        exp_t e;
        string t;
        e = exq.pop_front();
        t = tagq.pop_front();
        cmp(t, "left_atten", left_atten, e.la);
        cmp(t, "left_mute", {9'd0, left_mute}, {9'd0, e.lm});
        cmp(t, "right_atten", right_atten, e.ra);
        cmp(t, "right_mute", {9'd0, right_mute}, {9'd0, e.rm});
        cmp(t, "deemph_sel", {8'd0, deemph_sel}, {8'd0, e.de});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m = dflt();
    m_sh = '0;
    m_cnt = 0;
    repeat (2) @(negedge clk);
    do_reset("R1 reset defaults");
    // R2 left, ignored bits [12:10] set
    send_bits({16'd0, 2'b00, 1'b1, 3'b111, 10'h155}, 16, 2); load(); push("R2 left write");
    // R3 right
    send_bits({16'd0, 2'b01, 1'b0, 3'b101, 10'h2AA}, 16, 2); load(); push("R3 right write");
    send_bits({16'd0, 2'b01, 1'b1, 3'b000, 10'h001}, 16, 2); load(); push("R3 right mute");
    // R4 mode
    send_bits({16'd0, 2'b10, 14'h0001}, 16, 2); load(); push("R4 deemph 32k");
    send_bits({16'd0, 2'b10, 14'h3FFE}, 16, 2); load(); push("R4 deemph 48k");
    // R5 reserved target
    send_bits({16'd0, 2'b11, 1'b1, 13'h1234}, 16, 2); load(); push("R5 reserved target");
    // R6 short word
    send_bits({20'd0, 12'hABC}, 12, 2); load(); push("R6 short word");
    send_bits({16'd0, 2'b00, 1'b0, 3'b000, 10'h000}, 16, 2); load(); push("R6 full word after short");
    // R7 24 bits, last 16 kept
    send_bits({8'd0, 8'hB7, 2'b01, 1'b1, 3'b010, 10'h0F0}, 24, 2); load(); push("R7 keep last 16");
    // R8 bits without load change nothing, then load alone commits
    send_bits({16'd0, 2'b00, 1'b1, 3'b000, 10'h3C3}, 16, 2); push("R8 no load no change");
    load(); push("R8 load commits held word");
    // R9 gated clock with long pauses
    send_bits({16'd0, 2'b01, 1'b0, 3'b011, 10'h2D9}, 16, 40); load(); push("R9 gated clock");
    // R10 reset mid-word: 10 bits, reset, 6 bits + load is short
    send_bits({22'd0, 10'h3FF}, 10, 2);
    do_reset("R10 reset clears settings");
    send_bits({26'd0, 6'h15}, 6, 2); load(); push("R10 partial bits discarded");
    send_bits({16'd0, 2'b00, 1'b1, 3'b000, 10'h07E}, 16, 2); load(); push("R2 left after reset");
    wait (exq.size() == 0);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule